// File: doc/BRIEF.md
# Burst Transaction Splitter

This block sits between an application command queue and the waveform engine of a pseudo-static RAM controller. It takes commands made of a direction flag, a 21-bit word address and a 21-bit word count. It cuts each one into memory-bus sub-transactions that a single chip-enable window can carry. Each sub-transaction leaves on a valid/ready port as a start address, a length and a few flags. The command is acknowledged only after its final piece has been taken, so a fall-through FIFO can be popped directly with `cmd_ack`.

The cut rules depend on the operating mode captured when the command is accepted. In synchronous sequential bursts a piece stops at the end of the memory page or at the build-time length cap, whichever comes first. In wrap-burst mode every piece is one configured burst, and the offset inside the aligned burst is kept from piece to piece. In asynchronous mode every word is its own piece. A chip-enable duration timer tags any piece issued after the timer has run out, which tells the engine to release chip enable once that piece ends.

Top module: `burst_splitter`

## Requirements
- R1: After reset, `sub_valid` and `cmd_ack` are both low.
- R2: A command is taken only while `cfg_mode` is 00 (synchronous) or 01 (asynchronous). While `cfg_mode[1]` is 1 (either configuration mode), a pending command issues no piece and gets no acknowledge.
- R3: In synchronous mode with wrap off, each piece length is the smallest of three values: the words left in the command, the words left before the page end, and MAX_SUB. The next piece starts at address plus length, modulo 2^21.
- R4: `cfg_page_sel` selects the page size: 0 gives 256 words, 1 gives 1024, and 2 or 3 give 2048. No non-wrap piece crosses a page boundary.
- R5: In asynchronous mode every piece has length 1, and addresses step by one.
- R6: In wrap mode (synchronous with `cfg_wrap`=1), `cfg_burst_sel` 0..3 selects a burst B of 4, 8, 16 or 32 words. Each piece has length min(words left, B), and the next piece starts B words later, so the offset within the aligned burst stays the same.
- R7: A word count of zero is handled as one word. The piece lengths of a command always add up to its effective count, and no piece has length zero.
- R8: While `sub_valid` is high and `sub_ready` is low, all piece outputs hold steady.
- R9: `sub_last` marks the final piece. `cmd_ack` is a one-cycle pulse, given once per command, in the cycle after the final piece is taken. While it is high, no piece is valid.
- R10: A chip-enable timer is cleared while `ce_idle` is high and otherwise counts cycles, saturating at its maximum. A piece carries `sub_ce_break`=1 exactly when the count is at or above `cfg_tcem_limit` in the cycle the piece is loaded.
- R11: The mode, wrap, burst and page settings are captured when the command is accepted. Changing them mid-command does not change how that command is split.
- R12: `sub_write` equals the `cmd_write` value of the command the piece belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command pending |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | First word address |
| cmd_count | input | CNT_W | Word count (0 handled as 1) |
| cmd_ack | output | 1 | Command fully issued, pop next |
| cfg_mode | input | 2 | 00 sync, 01 async, 10/11 configuration |
| cfg_wrap | input | 1 | Wrap-burst mode in synchronous mode |
| cfg_burst_sel | input | 2 | Burst size code 4/8/16/32 |
| cfg_page_sel | input | 2 | Page size code 256/1024/2048 |
| cfg_tcem_limit | input | TCEM_W | Chip-enable duration limit in cycles |
| ce_idle | input | 1 | Engine reports chip enable released |
| sub_valid | output | 1 | Piece available |
| sub_ready | input | 1 | Engine takes the piece |
| sub_addr | output | ADDR_W | Piece start address |
| sub_len | output | CNT_W | Piece length in words |
| sub_write | output | 1 | Piece direction |
| sub_last | output | 1 | Final piece of the command |
| sub_ce_break | output | 1 | Release chip enable after this piece |

## Verification
The bench builds the splitter with MAX_SUB set to 16. This lets counts of a few dozen words run into the length cap, the page end and the burst size in the same command. It sweeps every page code with start addresses just below a page end, every burst code with offsets from zero to B-1, and asynchronous runs that cross the top of the address space. A repeating ready pattern adds backpressure throughout. Directed cases cover configuration hold-off, a mode change in mid-command and both states of the chip-enable timer.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_ACK   = 2'd3
  } bsp_state_t;

  localparam logic [1:0] MODE_SYNC  = 2'b00;
  localparam logic [1:0] MODE_ASYNC = 2'b01;
endpackage

// File: rtl/bsp_len_calc.sv
module bsp_len_calc #(
  parameter int ADDR_W         = 21,
  parameter int CNT_W          = 21,
  parameter int MAX_SUB        = 64,
  parameter int PAGE_MIN_LOG2  = 8,
  parameter int BURST_MIN_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  rem,
  input  logic              async_md,
  input  logic              wrap_md,
  input  logic [1:0]        bsel,
  input  logic [1:0]        psel,
  output logic [CNT_W-1:0]  len,
  output logic [ADDR_W-1:0] next_addr,
  output logic              last
);
  localparam logic [CNT_W-1:0] CAP_SEQ = CNT_W'(MAX_SUB);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] page_words;
  logic [CNT_W-1:0] page_off;
  logic [CNT_W-1:0] page_left;
  logic [CNT_W-1:0] burst_words;
  logic [CNT_W-1:0] seq_cap;
  logic [CNT_W-1:0] cap;

  always_comb begin
    case (psel)
      2'd0:    page_words = ONE << PAGE_MIN_LOG2;
      2'd1:    page_words = ONE << (PAGE_MIN_LOG2 + 2);
      default: page_words = ONE << (PAGE_MIN_LOG2 + 3);
    endcase
    burst_words = ONE << (BURST_MIN_LOG2 + int'(bsel));
    page_off    = CNT_W'(addr) & (page_words - ONE);
    page_left   = page_words - page_off;
    seq_cap     = (page_left < CAP_SEQ) ? page_left : CAP_SEQ;
    if (async_md)     cap = ONE;
    else if (wrap_md) cap = burst_words;
    else              cap = seq_cap;
    len  = (rem < cap) ? rem : cap;
    last = (rem == len);
    if (wrap_md && !async_md) next_addr = addr + ADDR_W'(burst_words);
    else                      next_addr = addr + ADDR_W'(len);
  end
endmodule

// File: rtl/bsp_ce_timer.sv
module bsp_ce_timer #(
  parameter int TCEM_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_idle,
  input  logic [TCEM_W-1:0] limit,
  output logic              expired
);
  logic [TCEM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || ce_idle)  cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/bsp_sub_reg.sv
module bsp_sub_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int ADDR_W         = 21,
  parameter int CNT_W          = 21,
  parameter int MAX_SUB        = 64,
  parameter int TCEM_W         = 12,
  parameter int PAGE_MIN_LOG2  = 8,
  parameter int BURST_MIN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_ack,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wrap,
  input  logic [1:0]        cfg_burst_sel,
  input  logic [1:0]        cfg_page_sel,
  input  logic [TCEM_W-1:0] cfg_tcem_limit,
  input  logic              ce_idle,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [CNT_W-1:0]  sub_len,
  output logic              sub_write,
  output logic              sub_last,
  output logic              sub_ce_break
);
  import bsp_pkg::*;

  localparam int PAY_W = ADDR_W + CNT_W + 3;

  bsp_state_t        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  rem;
  logic              snap_write;
  logic              snap_async;
  logic              snap_wrap;
  logic [1:0]        snap_bsel;
  logic [1:0]        snap_psel;

  logic [CNT_W-1:0]  calc_len;
  logic [ADDR_W-1:0] calc_next;
  logic              calc_last;
  logic              ce_expired;
  logic              sub_free;
  logic              load;
  logic              accept;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  bsp_len_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_SUB(MAX_SUB),
    .PAGE_MIN_LOG2(PAGE_MIN_LOG2), .BURST_MIN_LOG2(BURST_MIN_LOG2)
  ) u_calc (
    .addr(cur_addr), .rem(rem), .async_md(snap_async), .wrap_md(snap_wrap),
    .bsel(snap_bsel), .psel(snap_psel),
    .len(calc_len), .next_addr(calc_next), .last(calc_last)
  );

  bsp_ce_timer #(.TCEM_W(TCEM_W)) u_timer (
    .clk(clk), .rst(rst), .ce_idle(ce_idle),
    .limit(cfg_tcem_limit), .expired(ce_expired)
  );

  assign accept = (state == ST_IDLE) && cmd_valid && !cfg_mode[1];
  assign load   = (state == ST_ISSUE) && sub_free;
  assign pay_in = {cur_addr, calc_len, calc_last, snap_write, ce_expired};

  bsp_sub_reg #(.W(PAY_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .din(pay_in),
    .ready(sub_ready), .valid(sub_valid), .dout(pay_out), .free(sub_free)
  );

  assign {sub_addr, sub_len, sub_last, sub_write, sub_ce_break} = pay_out;
  assign cmd_ack = (state == ST_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      rem        <= '0;
      snap_write <= 1'b0;
      snap_async <= 1'b0;
      snap_wrap  <= 1'b0;
      snap_bsel  <= '0;
      snap_psel  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cur_addr   <= cmd_addr;
          rem        <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
          snap_write <= cmd_write;
          snap_async <= (cfg_mode == MODE_ASYNC);
          snap_wrap  <= (cfg_mode == MODE_SYNC) && cfg_wrap;
          snap_bsel  <= cfg_burst_sel;
          snap_psel  <= cfg_page_sel;
          state      <= ST_ISSUE;
        end
        ST_ISSUE: if (load) begin
          cur_addr <= calc_next;
          rem      <= rem - calc_len;
          if (calc_last) state <= ST_DRAIN;
        end
        ST_DRAIN: if (sub_valid && sub_ready) state <= ST_ACK;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsp_chk.sv
module bsp_chk #(
  parameter int ADDR_W         = 21,
  parameter int CNT_W          = 21,
  parameter int MAX_SUB        = 64,
  parameter int PAGE_MIN_LOG2  = 8,
  parameter int BURST_MIN_LOG2 = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [CNT_W-1:0]  sub_len,
  input logic              sub_last,
  input logic              sub_write,
  input logic              cmd_ack,
  input logic              snap_async,
  input logic              snap_wrap,
  input logic [1:0]        snap_bsel,
  input logic [1:0]        snap_psel
);
  logic [CNT_W:0] pg;
  logic [CNT_W:0] off_end;
  logic [CNT_W:0] bw;

  always_comb begin
    case (snap_psel)
      2'd0:    pg = (CNT_W+1)'(1) << PAGE_MIN_LOG2;
      2'd1:    pg = (CNT_W+1)'(4) << PAGE_MIN_LOG2;
      default: pg = (CNT_W+1)'(8) << PAGE_MIN_LOG2;
    endcase
    bw      = (CNT_W+1)'(1) << (BURST_MIN_LOG2 + int'(snap_bsel));
    off_end = ((CNT_W+1)'(sub_addr) & (pg - 1'b1)) + (CNT_W+1)'(sub_len);
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_len)
      && $stable(sub_last) && $stable(sub_write));
  assert_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    sub_valid |-> sub_len != '0);
  assert_single_R5: assert property (@(posedge clk) disable iff (rst)
    sub_valid && snap_async |-> sub_len == CNT_W'(1));
  assert_cap_R3: assert property (@(posedge clk) disable iff (rst)
    sub_valid && !snap_wrap |-> sub_len <= CNT_W'(MAX_SUB));
  assert_page_R4: assert property (@(posedge clk) disable iff (rst)
    sub_valid && !snap_wrap |-> off_end <= pg);
  assert_burst_R6: assert property (@(posedge clk) disable iff (rst)
    sub_valid && snap_wrap |-> (CNT_W+1)'(sub_len) <= bw);
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> !cmd_ack);
  assert_ack_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |-> !sub_valid);
endmodule

bind burst_splitter bsp_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_SUB(MAX_SUB),
  .PAGE_MIN_LOG2(PAGE_MIN_LOG2), .BURST_MIN_LOG2(BURST_MIN_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_ready(sub_ready),
  .sub_addr(sub_addr), .sub_len(sub_len), .sub_last(sub_last),
  .sub_write(sub_write), .cmd_ack(cmd_ack), .snap_async(snap_async),
  .snap_wrap(snap_wrap), .snap_bsel(snap_bsel), .snap_psel(snap_psel)
);

// File: tb/burst_splitter_bench.sv
module burst_splitter_bench;
  localparam int MAXS = 16;
  localparam int AMASK = 32'h1F_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [20:0] cmd_addr = '0;
  logic [20:0] cmd_count = '0;
  logic        cmd_ack;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_wrap = 1'b0;
  logic [1:0]  cfg_burst_sel = '0;
  logic [1:0]  cfg_page_sel = '0;
  logic [11:0] cfg_tcem_limit = 12'd4000;
  logic        ce_idle = 1'b1;
  logic        sub_valid;
  logic        sub_ready = 1'b1;
  logic [20:0] sub_addr;
  logic [20:0] sub_len;
  logic        sub_write;
  logic        sub_last;
  logic        sub_ce_break;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_splitter #(.MAX_SUB(MAXS)) u_burst_splitter (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_ack(cmd_ack),
    .cfg_mode(cfg_mode), .cfg_wrap(cfg_wrap), .cfg_burst_sel(cfg_burst_sel),
    .cfg_page_sel(cfg_page_sel), .cfg_tcem_limit(cfg_tcem_limit), .ce_idle(ce_idle),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_len(sub_len), .sub_write(sub_write), .sub_last(sub_last),
    .sub_ce_break(sub_ce_break)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int page_of(input int ps);
    return (ps == 0) ? 256 : (ps == 1) ? 1024 : 2048;
  endfunction

  // exp_brk: expected sub_ce_break value (R10); flip changes cfg mid-command (R11)
  task automatic run_cmd(input bit wr, input int addr, input int cnt, input logic [1:0] md,
                         input bit wrp, input int bs, input int ps, input int exp_brk,
                         input bit flip);
    int ea, er, k, nsub, guard, elen, enext, cap, pw, bw;
    bit done;
    cmd_write = wr; cmd_addr = addr[20:0]; cmd_count = cnt[20:0];
    cfg_mode = md; cfg_wrap = wrp; cfg_burst_sel = bs[1:0]; cfg_page_sel = ps[1:0];
    cmd_valid = 1'b1;
    ea = addr & AMASK; er = (cnt == 0) ? 1 : cnt;
    k = 0; nsub = 0; guard = 0; done = 1'b0;
    pw = page_of(ps); bw = 4 << bs;
    while (!done) begin
      @(negedge clk);
      if (sub_valid && sub_ready) begin
        if (md == 2'b01) begin
          elen = 1; enext = ea + 1;                       // R5
        end else if (wrp) begin
          elen = (er < bw) ? er : bw; enext = ea + bw;     // R6
        end else begin
          cap = pw - (ea % pw); if (cap > MAXS) cap = MAXS; // R3 R4
          elen = (er < cap) ? er : cap; enext = ea + elen;
        end
        chk(int'(sub_addr) == ea, "R3/R5/R6 addr", int'(sub_addr), ea);
        chk(int'(sub_len) == elen, "R3/R4/R6 len", int'(sub_len), elen);
        chk(sub_last == (er == elen), "R9 last", int'(sub_last), int'(er == elen));
        chk(sub_write == wr, "R12 write", int'(sub_write), int'(wr));
        chk(int'(sub_ce_break) == exp_brk, "R10 break", int'(sub_ce_break), exp_brk);
        er -= elen; ea = enext & AMASK; nsub++;
        if (flip && nsub == 1) begin
          cfg_mode = 2'b11; cfg_wrap = ~wrp; cfg_page_sel = 2'd3; cfg_burst_sel = ~bs[1:0];
        end
      end
      if (cmd_ack) begin
        chk(er == 0, "R7 total words", er, 0);
        done = 1'b1;
      end
      sub_ready = (k % 3) != 2;
      k++; guard++;
      if (guard > 20000) begin
        chk(1'b0, "R9 ack missing", 0, 1);
        done = 1'b1;
      end
    end
    cmd_valid = 1'b0; cfg_mode = md;
    @(negedge clk);
    chk(!cmd_ack, "R9 single ack", int'(cmd_ack), 0);
    sub_ready = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sub_valid, "R1 sub_valid", int'(sub_valid), 0);
    chk(!cmd_ack, "R1 cmd_ack", int'(cmd_ack), 0);

    // R3 R4 R7: sequential sweep over page codes, near page ends
    for (int ps = 0; ps < 4; ps++) begin
      for (int ki = 0; ki < 4; ki++) begin
        for (int li = 0; li < 5; li++) begin
          int kk, ll;
          kk = (ki == 0) ? 1 : (ki == 1) ? 2 : (ki == 2) ? 7 : 16;
          ll = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : (li == 3) ? 17 : 40;
          run_cmd(li[0], page_of(ps) * 3 - kk, ll, 2'b00, 1'b0, 0, ps, 0, 1'b0);
        end
      end
    end

    // R5: asynchronous, including wrap of the address space
    run_cmd(1'b0, 100, 0, 2'b01, 1'b0, 0, 0, 0, 1'b0);
    run_cmd(1'b1, 253, 9, 2'b01, 1'b1, 1, 0, 0, 1'b0);
    run_cmd(1'b0, AMASK - 2, 6, 2'b01, 1'b0, 0, 1, 0, 1'b0);

    // R6: wrap bursts, every size and several offsets
    for (int bs = 0; bs < 4; bs++) begin
      for (int oi = 0; oi < 4; oi++) begin
        int bw, off;
        bw = 4 << bs;
        off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 3 : bw - 1;
        run_cmd(oi[0], 4096 + off, 1, 2'b00, 1'b1, bs, 0, 0, 1'b0);
        run_cmd(oi[0], 4096 + 256 - bw + off, 2 * bw + 3, 2'b00, 1'b1, bs, 0, 0, 1'b0);
      end
    end

    // R2: configuration modes hold off a pending command
    for (int m = 2; m < 4; m++) begin
      cmd_addr = 21'd50; cmd_count = 21'd4; cfg_mode = m[1:0]; cmd_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(!sub_valid && !cmd_ack, "R2 hold-off", int'(sub_valid), 0);
      end
      run_cmd(1'b1, 50, 4, 2'b00, 1'b0, 0, 0, 0, 1'b0);
    end

    // R11: settings changed mid-command do not alter the split
    run_cmd(1'b0, 250, 30, 2'b00, 1'b0, 0, 0, 0, 1'b1);
    run_cmd(1'b1, 2049, 20, 2'b00, 1'b1, 1, 0, 0, 1'b1);
    run_cmd(1'b0, 70, 5, 2'b01, 1'b0, 2, 1, 0, 1'b1);

    // R10: timer expired vs held idle
    cfg_tcem_limit = 12'd10; ce_idle = 1'b0;
    repeat (30) @(negedge clk);
    run_cmd(1'b1, 500, 40, 2'b00, 1'b0, 0, 0, 1, 1'b0);
    ce_idle = 1'b1;
    run_cmd(1'b0, 500, 40, 2'b00, 1'b0, 0, 0, 0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule